// File: doc/BRIEF.md
# Indexed Framebuffer Scanout Overlay

This block draws a small byte-per-pixel framebuffer on top of a text-mode video stream. Every framebuffer byte is a colour index into a 256-entry RGB palette. Each source pixel is shown as a 2x2 block of screen pixels, and the whole image sits in the top-left corner of the frame. Outside that area, or while the overlay is off, the text stream's colour passes through unchanged.

There are two framebuffers. Software draws into one while the other is on screen, then swaps them with a single register write. Each buffer RAM has two ports: a CPU port (byte read and write) on the CPU clock, and a readout port on the pixel clock. The timing generator supplies horizontal and vertical counters that run three pixels ahead of the text stream. The block turns these into framebuffer addresses, looks up the palette, and produces the colour for the current text pixel.

The enable and buffer-select registers are synchronised into the pixel domain. They are applied only when the first blanking line starts, so no frame ever shows a mix of settings.

Top module: `idx_overlay`

## Requirements
- R1: After reset the overlay is off, `rgb_o` equals `txt_rgb_i`, and `cpu_rdata_o` is zero.
- R2: While the applied enable is set, a screen pixel at (h, v) with h < 2*FB_W and v < 2*FB_H shows `palette[buf[(v>>1)*FB_W + (h>>1)]]`, so every source pixel covers a 2x2 screen block.
- R3: A screen pixel with h >= 2*FB_W or v >= 2*FB_H shows `txt_rgb_i`.
- R4: The counters lead the text stream by three pixel clocks. Coordinates sampled at pixel edge k decide `rgb_o` in the cycle after edge k+2, and that output is combined with the `txt_rgb_i` present in that cycle.
- R5: A CPU write to control offset 2 stores one palette entry. Data bits 31:24 are the index, 23:16 red, 15:8 green and 7:0 blue. `rgb_o` carries red in 23:16, green in 15:8 and blue in 7:0.
- R6: Address bits [CPU_AW-1:CPU_AW-2] select the region: 0 is buffer 0, 1 is buffer 1, 2 is control. Control offset 1, bit 0 chooses which buffer is displayed, so the buffer not on screen can be rewritten without any visible change.
- R7: The enable (control offset 0, bit 0) and the select are sampled only when the counters present h = 0 and v = V_ACTIVE. A write made mid-frame takes effect at the next such point.
- R8: A CPU byte read of a buffer returns the byte zero-extended on `cpu_rdata_o` in the cycle after the request. In any cycle not following a read, `cpu_rdata_o` is zero.
- R9: A read of control offset 0 or 1 returns the register value written there in bit 0. Control offsets are decoded from the two lowest address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU port clock |
| pix_clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| cpu_req_i | input | 1 | CPU access strobe |
| cpu_we_i | input | 1 | CPU write when high, read when low |
| cpu_addr_i | input | CPU_AW | Region in the top two bits, offset below |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rdata_o | output | 32 | CPU read data, one cycle after the request |
| h_pre_i | input | CNT_W | Prefetched horizontal counter |
| v_pre_i | input | CNT_W | Prefetched vertical counter |
| txt_rgb_i | input | 24 | Text-mode pixel colour |
| rgb_o | output | 24 | Output pixel colour |

## Verification
The colour for the coordinates driven on a pixel edge is due in the cycle after the third edge that follows (address register, buffer RAM, palette RAM). The reference model therefore keeps a four-slot ring of expected pixels. It compares each slot three pixel cycles after that slot's coordinates were driven, against the text colour driven in the same cycle. Register writes are expected to show only from the first frame whose leading blanking line begins after the write, so the model moves its own copy of enable and select only at that point. CPU reads are sampled one CPU cycle after the request.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;
  localparam int PAL_IW = 8;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  typedef enum logic [1:0] {
    RGN_BUF0 = 2'd0,
    RGN_BUF1 = 2'd1,
    RGN_CTRL = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

  localparam logic [1:0] CTL_EN  = 2'd0;
  localparam logic [1:0] CTL_SEL = 2'd1;
  localparam logic [1:0] CTL_PAL = 2'd2;
endpackage

// File: rtl/ovl_fb_ram.sv
module ovl_fb_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 640,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          a_clk_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_clk_i,
  input  logic [AW-1:0] b_addr_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge a_clk_i) begin
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    a_rdata_o <= mem_q[a_addr_i];
  end

  always_ff @(posedge b_clk_i) begin
    b_rdata_o <= mem_q[b_addr_i];
  end
endmodule

// File: rtl/ovl_pal_ram.sv
module ovl_pal_ram
  import ovl_pkg::*;
(
  input  logic              w_clk_i,
  input  logic              w_en_i,
  input  logic [PAL_IW-1:0] w_idx_i,
  input  rgb_t              w_data_i,
  input  logic              r_clk_i,
  input  logic [PAL_IW-1:0] r_idx_i,
  output rgb_t              r_data_o
);
  localparam int N = 1 << PAL_IW;
  rgb_t mem_q [N];

  always_ff @(posedge w_clk_i) begin
    if (w_en_i) mem_q[w_idx_i] <= w_data_i;
  end

  always_ff @(posedge r_clk_i) begin
    r_data_o <= mem_q[r_idx_i];
  end
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int V_ACTIVE = 72
) (
  input  logic              cpu_clk_i,
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic              ctl_hit_i,
  input  logic              cpu_we_i,
  input  logic [1:0]        ctl_off_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic              ctl_bit_o,
  output logic              pal_we_o,
  output logic [PAL_IW-1:0] pal_idx_o,
  output rgb_t              pal_rgb_o,
  input  logic [CNT_W-1:0]  h_pre_i,
  input  logic [CNT_W-1:0]  v_pre_i,
  output logic              shd_en_o,
  output logic              shd_sel_o
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(V_ACTIVE);

  logic en_q, sel_q;
  logic en_s1, en_s2, sel_s1, sel_s2;
  logic frame_cap;

  // cpu domain registers
  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      sel_q     <= 1'b0;
      ctl_bit_o <= 1'b0;
    end else begin
      if (ctl_hit_i && cpu_we_i && ctl_off_i == CTL_EN)  en_q  <= cpu_wdata_i[0];
      if (ctl_hit_i && cpu_we_i && ctl_off_i == CTL_SEL) sel_q <= cpu_wdata_i[0];
      ctl_bit_o <= ctl_hit_i && !cpu_we_i &&
                   ((ctl_off_i == CTL_EN && en_q) || (ctl_off_i == CTL_SEL && sel_q));
    end
  end

  assign pal_we_o  = ctl_hit_i && cpu_we_i && ctl_off_i == CTL_PAL;
  assign pal_idx_o = cpu_wdata_i[31:24];
  assign pal_rgb_o = cpu_wdata_i[23:0];

  // pixel domain: two-flop sync, then frame-boundary capture
  assign frame_cap = (v_pre_i == CAP_V) && (h_pre_i == '0);

  always_ff @(posedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1     <= 1'b0;
      en_s2     <= 1'b0;
      sel_s1    <= 1'b0;
      sel_s2    <= 1'b0;
      shd_en_o  <= 1'b0;
      shd_sel_o <= 1'b0;
    end else begin
      en_s1  <= en_q;
      en_s2  <= en_s1;
      sel_s1 <= sel_q;
      sel_s2 <= sel_s1;
      if (frame_cap) begin
        shd_en_o  <= en_s2;
        shd_sel_o <= sel_s2;
      end
    end
  end

  p_frame_hold_r7: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    !frame_cap |=> ($stable(shd_en_o) && $stable(shd_sel_o)))
    else $error("applied enable/select changed away from frame start");
endmodule

// File: rtl/ovl_scan.sv
module ovl_scan
  import ovl_pkg::*;
#(
  parameter int FB_W  = 32,
  parameter int FB_H  = 20,
  parameter int CNT_W = 12,
  parameter int FB_AW = $clog2(FB_W * FB_H)
) (
  input  logic                pix_clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    h_pre_i,
  input  logic [CNT_W-1:0]    v_pre_i,
  input  logic                shd_en_i,
  input  logic                shd_sel_i,
  output logic [FB_AW-1:0]    fb_raddr_o,
  input  logic [1:0][CH_W-1:0] fb_rdata_i,
  output logic [PAL_IW-1:0]   pal_idx_o,
  input  rgb_t                pal_rgb_i,
  input  rgb_t                txt_rgb_i,
  output rgb_t                rgb_o
);
  localparam int FB_PIX = FB_W * FB_H;
  localparam logic [CNT_W-1:0] VIEW_W_C = CNT_W'(2 * FB_W);
  localparam logic [CNT_W-1:0] VIEW_H_C = CNT_W'(2 * FB_H);
  localparam logic [FB_AW-1:0] ROW_C    = FB_AW'(FB_W);

  logic             in_view;
  logic [FB_AW-1:0] addr_d, addr_q;
  logic             sel_q0, sel_q1;
  logic [2:0]       win_q;

  // stage 0: halved coordinates -> linear address
  always_comb begin
    in_view = shd_en_i && (h_pre_i < VIEW_W_C) && (v_pre_i < VIEW_H_C);
    addr_d  = in_view ? FB_AW'(v_pre_i >> 1) * ROW_C + FB_AW'(h_pre_i >> 1) : '0;
  end

  always_ff @(posedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sel_q0 <= 1'b0;
      sel_q1 <= 1'b0;
      win_q  <= '0;
    end else begin
      addr_q <= addr_d;
      sel_q0 <= shd_sel_i;
      sel_q1 <= sel_q0;
      win_q  <= {win_q[1:0], in_view};
    end
  end

  assign fb_raddr_o = addr_q;
  assign pal_idx_o  = fb_rdata_i[sel_q1];
  assign rgb_o      = win_q[2] ? pal_rgb_i : txt_rgb_i;

  p_addr_in_range_r2: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    int'(fb_raddr_o) < FB_PIX)
    else $error("readout address beyond framebuffer");

  p_text_outside_r3: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    ($past(v_pre_i, 3) >= VIEW_H_C) |-> (rgb_o == txt_rgb_i))
    else $error("overlay colour below viewport");

  p_text_when_off_r1: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    !$past(shd_en_i, 3) |-> (rgb_o == txt_rgb_i))
    else $error("overlay colour while disabled");
endmodule

// File: rtl/idx_overlay.sv
module idx_overlay
  import ovl_pkg::*;
#(
  parameter int FB_W     = 32,
  parameter int FB_H     = 20,
  parameter int CNT_W    = 12,
  parameter int V_ACTIVE = 72,
  parameter int FB_AW    = $clog2(FB_W * FB_H),
  parameter int CPU_AW   = FB_AW + 2
) (
  input  logic              cpu_clk_i,
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  input  logic [CNT_W-1:0]  h_pre_i,
  input  logic [CNT_W-1:0]  v_pre_i,
  input  logic [23:0]       txt_rgb_i,
  output logic [23:0]       rgb_o
);
  localparam int NUM_BUF = 2;
  localparam int FB_PIX  = FB_W * FB_H;

  logic [1:0]                    rgn, rgn_q;
  logic [FB_AW-1:0]              off;
  logic [NUM_BUF-1:0][CH_W-1:0]  fb_a_rdata, fb_b_rdata;
  logic [FB_AW-1:0]              fb_raddr;
  logic                          ctl_bit, pal_we, shd_en, shd_sel;
  logic [PAL_IW-1:0]             pal_widx, pal_ridx;
  rgb_t                          pal_wrgb, pal_rrgb, txt_s, out_s;

  assign rgn = cpu_addr_i[CPU_AW-1 -: 2];
  assign off = cpu_addr_i[FB_AW-1:0];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    ovl_fb_ram #(.DW(CH_W), .DEPTH(FB_PIX), .AW(FB_AW)) i_fb (
      .a_clk_i   (cpu_clk_i),
      .a_we_i    (cpu_req_i && cpu_we_i && rgn == 2'(b)),
      .a_addr_i  (off),
      .a_wdata_i (cpu_wdata_i[CH_W-1:0]),
      .a_rdata_o (fb_a_rdata[b]),
      .b_clk_i   (pix_clk_i),
      .b_addr_i  (fb_raddr),
      .b_rdata_o (fb_b_rdata[b])
    );
  end

  ovl_ctrl #(.CNT_W(CNT_W), .V_ACTIVE(V_ACTIVE)) i_ctrl (
    .cpu_clk_i   (cpu_clk_i),
    .pix_clk_i   (pix_clk_i),
    .rst_ni      (rst_ni),
    .ctl_hit_i   (cpu_req_i && rgn == RGN_CTRL),
    .cpu_we_i    (cpu_we_i),
    .ctl_off_i   (off[1:0]),
    .cpu_wdata_i (cpu_wdata_i),
    .ctl_bit_o   (ctl_bit),
    .pal_we_o    (pal_we),
    .pal_idx_o   (pal_widx),
    .pal_rgb_o   (pal_wrgb),
    .h_pre_i     (h_pre_i),
    .v_pre_i     (v_pre_i),
    .shd_en_o    (shd_en),
    .shd_sel_o   (shd_sel)
  );

  ovl_pal_ram i_pal (
    .w_clk_i  (cpu_clk_i),
    .w_en_i   (pal_we),
    .w_idx_i  (pal_widx),
    .w_data_i (pal_wrgb),
    .r_clk_i  (pix_clk_i),
    .r_idx_i  (pal_ridx),
    .r_data_o (pal_rrgb)
  );

  assign txt_s = txt_rgb_i;

  ovl_scan #(.FB_W(FB_W), .FB_H(FB_H), .CNT_W(CNT_W), .FB_AW(FB_AW)) i_scan (
    .pix_clk_i  (pix_clk_i),
    .rst_ni     (rst_ni),
    .h_pre_i    (h_pre_i),
    .v_pre_i    (v_pre_i),
    .shd_en_i   (shd_en),
    .shd_sel_i  (shd_sel),
    .fb_raddr_o (fb_raddr),
    .fb_rdata_i (fb_b_rdata),
    .pal_idx_o  (pal_ridx),
    .pal_rgb_i  (pal_rrgb),
    .txt_rgb_i  (txt_s),
    .rgb_o      (out_s)
  );

  assign rgb_o = out_s;

  // read return: region remembered for one cycle, zero otherwise
  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) rgn_q <= RGN_NONE;
    else         rgn_q <= (cpu_req_i && !cpu_we_i) ? rgn : RGN_NONE;
  end

  always_comb begin
    cpu_rdata_o = '0;
    for (int b = 0; b < NUM_BUF; b++)
      if (rgn_q == 2'(b)) cpu_rdata_o = 32'(fb_a_rdata[b]);
    if (rgn_q == RGN_CTRL) cpu_rdata_o = 32'(ctl_bit);
  end

  p_rdata_idle_r8: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    !$past(cpu_req_i) |-> (cpu_rdata_o == '0))
    else $error("read data not zero when idle");
endmodule

// File: tb/test_idx_overlay.sv
module test_idx_overlay;
  localparam int PIX_PERIOD = 10;
  localparam int CPU_PERIOD = 14;
  localparam int FB_W   = 32;
  localparam int FB_H   = 20;
  localparam int FB_PIX = FB_W * FB_H;
  localparam int FB_AW  = 10;
  localparam int CPU_AW = 12;
  localparam int CNT_W  = 12;
  localparam int V_ACT  = 72;
  localparam int H_TOT  = 136;
  localparam int V_TOT  = 76;

  logic pix_clk = 1'b0, cpu_clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [CPU_AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [CNT_W-1:0] h_pre = '0, v_pre = '0;
  logic [23:0] txt_rgb = 24'h123456;
  logic [23:0] rgb;

  always #(PIX_PERIOD/2) pix_clk = ~pix_clk;
  always #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;

  idx_overlay #(.FB_W(FB_W), .FB_H(FB_H), .CNT_W(CNT_W), .V_ACTIVE(V_ACT)) i_idx_overlay (
    .cpu_clk_i(cpu_clk), .pix_clk_i(pix_clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .h_pre_i(h_pre), .v_pre_i(v_pre), .txt_rgb_i(txt_rgb), .rgb_o(rgb)
  );

  int fb_m [2][FB_PIX];
  int pal_m [256];
  bit en_m, sel_m, shd_en_m, shd_sel_m;
  int exp_q [4];
  string tag_q [4];
  string ph_tag = "R2";
  int n_chk, n_fail, n_frame, ph_c, pv_c, rd;
  bit go, done;

  function automatic int txt_of(int h, int v);
    return ((h & 255) << 16) | ((v & 255) << 8) | 8'h3c;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cpu_wr(int a, int d);
    @(negedge cpu_clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = CPU_AW'(a); cpu_wdata = d;
    @(negedge cpu_clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(int a, output int d);
    @(negedge cpu_clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = CPU_AW'(a);
    @(negedge cpu_clk);
    cpu_req = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic fb_wr(int b, int i, int d);
    fb_m[b][i] = d & 255;
    cpu_wr((b << FB_AW) | i, d);
  endtask

  task automatic pal_wr(int k, int c);
    pal_m[k] = c & 24'hffffff;
    cpu_wr((2 << FB_AW) | 2, (k << 24) | (c & 24'hffffff));   // R5 packing
  endtask

  task automatic wait_line(int v);
    do @(negedge pix_clk); while (!(pv_c == v && ph_c == 0));
  endtask

  task automatic wait_frames(int n);
    int t = n_frame + n;
    while (n_frame < t) @(negedge pix_clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // pixel stream and cycle-by-cycle reference (R2 R3 R4 R7)
  initial begin
    wait (go);
    for (int j = 0; !done; j++) begin
      @(negedge pix_clk);
      h_pre = CNT_W'(ph_c);
      v_pre = CNT_W'(pv_c);
      txt_rgb = 24'(txt_of(ph_c, pv_c));
      if (shd_en_m && ph_c < 2*FB_W && pv_c < 2*FB_H) begin
        exp_q[j%4] = pal_m[fb_m[shd_sel_m][(pv_c/2)*FB_W + ph_c/2]];
        tag_q[j%4] = {"R2/R4/", ph_tag};
      end else begin
        exp_q[j%4] = -1;
        tag_q[j%4] = shd_en_m ? "R3" : "R7";
      end
      if (ph_c == 0 && pv_c == V_ACT) begin
        shd_en_m = en_m; shd_sel_m = sel_m; n_frame++;
      end
      #1;
      if (j >= 3)   // R4: result of coordinates driven three cycles earlier
        check(tag_q[(j+1)%4], int'(rgb),
              exp_q[(j+1)%4] < 0 ? int'(txt_rgb) : exp_q[(j+1)%4]);
      ph_c++;
      if (ph_c == H_TOT) begin ph_c = 0; pv_c = (pv_c + 1) % V_TOT; end
    end
  end

  initial begin
    repeat (195000) @(posedge pix_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge pix_clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(rgb), 24'h123456);
    check("R1", cpu_rdata, 0);
    cpu_rd((2 << FB_AW) | 0, rd); check("R9", rd, 0);
    go = 1'b1;

    for (int k = 0; k < 256; k++) pal_wr(k, (k << 16) | ((255 - k) << 8) | ((k * 3) & 255));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < FB_PIX; i++) fb_wr(b, i, (i * 7 + b * 91 + 3) & 255);

    cpu_rd((0 << FB_AW) | 0, rd);   check("R8", rd, fb_m[0][0]);
    cpu_rd((1 << FB_AW) | 639, rd); check("R8", rd, fb_m[1][639]);
    cpu_rd((0 << FB_AW) | 333, rd); check("R8", rd, fb_m[0][333]);
    fb_wr(1, 5, 8'hAB);
    cpu_rd((1 << FB_AW) | 5, rd);   check("R8", rd, 8'hAB);
    @(negedge cpu_clk); @(negedge cpu_clk);
    check("R8", cpu_rdata, 0);

    // enable on buffer 0
    wait_line(V_ACT + 1);
    cpu_wr((2 << FB_AW) | 0, 1); en_m = 1'b1;
    cpu_wr((2 << FB_AW) | 1, 0); sel_m = 1'b0;
    cpu_rd((2 << FB_AW) | 0, rd); check("R9", rd, 1);
    wait_frames(2);

    // R6: flip to buffer 1
    wait_line(V_ACT + 1);
    ph_tag = "R6";
    cpu_wr((2 << FB_AW) | 1, 1); sel_m = 1'b1;
    cpu_rd((2 << FB_AW) | 1, rd); check("R9", rd, 1);
    wait_frames(2);
    for (int i = 0; i < 40; i++) fb_wr(0, i, (i * 13 + 5) & 255);  // R6 back buffer

    // R5: palette entry changed during blanking
    wait_line(V_ACT + 1);
    ph_tag = "R5";
    pal_wr(fb_m[1][0], 24'hFEDCBA);
    wait_frames(2);

    // R7: mid-frame writes wait for frame start
    wait_line(10);
    ph_tag = "R7";
    cpu_wr((2 << FB_AW) | 1, 0); sel_m = 1'b0;
    wait_frames(2);
    wait_line(10);
    cpu_wr((2 << FB_AW) | 0, 0); en_m = 1'b0;
    wait_frames(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule